// File: doc/BRIEF.md
# Lock-Protected Watchdog Timer

This block is a 16-bit down-counting watchdog whose reload value sits in two byte-wide registers, an upper byte and a lower byte. Software changes that value only through an ordered key sequence. First it writes two key bytes to the upper-byte address. Then it writes the new upper byte, and after that the new lower byte. The block locks itself again once the lower byte is written. Any write that breaks the order also locks it, so a stray write can never change the timeout period.

The counter moves down by one on each enabled tick. A refresh strobe copies the 16-bit reload value into it. On the tick where the count runs out, the block raises a one-cycle request. In normal running this is a reset request. In stop mode, if the watchdog is allowed to run there, it is a stop-mode recovery request instead. Both cases also set sticky status flags.

Top module: `wdog_guard`

## Requirements
- R1: While `rst` is high and after it falls, `count` is RST_COUNT and `reload_val` is RST_RELOAD. `reset_req`, `recover_req`, `flag_timeout` and `flag_stop` are all 0.
- R2: The key is 0x55 written with `wr_hi`=1, then 0xAA written with `wr_hi`=1 on the very next write. Neither key write changes `reload_val`.
- R3: After the key, the next write (with `wr_hi`=1) loads `reload_val[15:8]`. The write after it (with `wr_hi`=0) loads `reload_val[7:0]`. The block is then locked again, so later writes have no effect.
- R4: A write while locked has no effect on `reload_val`. So does any write that departs from the order in R2 and R3, and that write also returns the block to the locked state.
- R5: When `refresh` is high, `count` becomes `reload_val` on the next edge. This wins over a tick in the same cycle.
- R6: Each enabled tick lowers `count` by one. A tick that finds `count` at 1 or 0 is a timeout, and it loads `reload_val` into `count`.
- R7: A timeout outside stop mode, with `cfg_reset_en`=1, gives `reset_req` high for exactly the following cycle and sets `flag_timeout`.
- R8: A timeout in stop mode, with `cfg_reset_en`=1 and `cfg_stop_run`=1, gives a one-cycle `recover_req` and no `reset_req`. It sets both `flag_timeout` and `flag_stop`.
- R9: In stop mode with `cfg_stop_run`=0, ticks are ignored and `count` holds.
- R10: The flags stay set until `status_clr` is high. If a new timeout sets a flag in the same cycle as `status_clr`, the flag ends up set.
- R11: With `cfg_reset_en`=0, a timeout still reloads the counter, but it raises no request and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_hi | input | 1 | Write target: 1 = upper reload byte, 0 = lower reload byte |
| wr_data | input | 8 | Write data |
| refresh | input | 1 | Service strobe: reload the counter |
| tick | input | 1 | Counter tick enable |
| stop_mode | input | 1 | Device is in stop mode |
| cfg_reset_en | input | 1 | A timeout raises a request |
| cfg_stop_run | input | 1 | Counter keeps running in stop mode |
| status_clr | input | 1 | Clear both status flags |
| reset_req | output | 1 | One-cycle reset request |
| recover_req | output | 1 | One-cycle stop-mode recovery request |
| flag_timeout | output | 1 | Sticky watchdog timeout flag |
| flag_stop | output | 1 | Sticky flag: the timeout happened in stop mode |
| reload_val | output | 16 | Current reload value, upper byte then lower byte |
| count | output | 16 | Current counter value |

## Verification
The assertions check several rules on every cycle. The two requests never occur together, and each one comes with its status flags. A recovery request only follows a cycle in stop mode, and a reset request never does. The reload value changes only right after a write. The count holds when there is neither a tick nor a refresh. A flag falls only after a clear. What the assertions cannot show is whether the right byte lands in the right place after exactly the key order, and whether every broken order relocks. The bench's write scenarios, checked against a separate model, show that, along with the exact cycle of each timeout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        LK_SHUT    = 2'd0,
        LK_KEYED   = 2'd1,
        LK_WANT_HI = 2'd2,
        LK_WANT_LO = 2'd3
    } lock_state_e;

    typedef struct packed {
        logic              we;
        logic              sel_hi;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic fire;
        logic in_stop;
    } timeout_t;

    function automatic logic key_match(reg_wr_t w, logic [BYTE_W-1:0] key);
        return w.we && w.sel_hi && (w.data == key);
    endfunction
endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
    import wdg_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_RELOAD = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    output logic [CNT_W-1:0] reload
);
    lock_state_e state_q, state_d;
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic load_hi, load_lo;

    always_comb begin
        state_d = state_q;
        load_hi = 1'b0;
        load_lo = 1'b0;
        if (wr.we) begin
            unique case (state_q)
                LK_SHUT:    state_d = key_match(wr, KEY_FIRST) ? LK_KEYED : LK_SHUT;
                LK_KEYED:   state_d = key_match(wr, KEY_SECOND) ? LK_WANT_HI : LK_SHUT;
                LK_WANT_HI: begin
                    load_hi = wr.sel_hi;
                    state_d = wr.sel_hi ? LK_WANT_LO : LK_SHUT;
                end
                LK_WANT_LO: begin
                    load_lo = !wr.sel_hi;
                    state_d = LK_SHUT;
                end
                default:    state_d = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_SHUT;
            hi_q    <= RST_RELOAD[CNT_W-1:BYTE_W];
            lo_q    <= RST_RELOAD[BYTE_W-1:0];
        end else begin
            state_q <= state_d;
            if (load_hi) hi_q <= wr.data;
            if (load_lo) lo_q <= wr.data;
        end
    end

    assign reload = {hi_q, lo_q};
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_COUNT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             refresh,
    input  logic             tick,
    input  logic             stop_mode,
    input  logic             cfg_stop_run,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output timeout_t         to
);
    logic [CNT_W-1:0] cnt_q;
    logic run;

    assign run = tick && (!stop_mode || cfg_stop_run);

    always_comb begin
        to.fire    = !refresh && run && (cnt_q <= CNT_W'(1));
        to.in_stop = stop_mode;
    end

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= RST_COUNT;
        else if (refresh)         cnt_q <= reload;
        else if (to.fire)         cnt_q <= reload;
        else if (run)             cnt_q <= cnt_q - CNT_W'(1);
    end

    assign count = cnt_q;
endmodule

// File: rtl/wdg_status.sv
module wdg_status
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  timeout_t to,
    input  logic     cfg_reset_en,
    input  logic     clr,
    output logic     reset_req,
    output logic     recover_req,
    output logic     flag_wd,
    output logic     flag_stp
);
    logic hit_norm, hit_stop;

    assign hit_norm = to.fire && cfg_reset_en && !to.in_stop;
    assign hit_stop = to.fire && cfg_reset_en && to.in_stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_req   <= 1'b0;
            recover_req <= 1'b0;
            flag_wd     <= 1'b0;
            flag_stp    <= 1'b0;
        end else begin
            reset_req   <= hit_norm;
            recover_req <= hit_stop;
            if (hit_norm || hit_stop) flag_wd <= 1'b1;
            else if (clr)             flag_wd <= 1'b0;
            if (hit_stop)             flag_stp <= 1'b1;
            else if (clr)             flag_stp <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdg_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_COUNT  = 16'hFFFF,
    parameter logic [CNT_W-1:0] RST_RELOAD = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              refresh,
    input  logic              tick,
    input  logic              stop_mode,
    input  logic              cfg_reset_en,
    input  logic              cfg_stop_run,
    input  logic              status_clr,
    output logic              reset_req,
    output logic              recover_req,
    output logic              flag_timeout,
    output logic              flag_stop,
    output logic [CNT_W-1:0]  reload_val,
    output logic [CNT_W-1:0]  count
);
    reg_wr_t  wr;
    timeout_t to;

    assign wr = '{we: wr_en, sel_hi: wr_hi, data: wr_data};

    wdg_unlock #(.RST_RELOAD(RST_RELOAD)) u_unlock (
        .clk(clk), .rst(rst), .wr(wr), .reload(reload_val)
    );

    wdg_counter #(.RST_COUNT(RST_COUNT)) u_counter (
        .clk(clk), .rst(rst), .refresh(refresh), .tick(tick),
        .stop_mode(stop_mode), .cfg_stop_run(cfg_stop_run),
        .reload(reload_val), .count(count), .to(to)
    );

    wdg_status u_status (
        .clk(clk), .rst(rst), .to(to), .cfg_reset_en(cfg_reset_en),
        .clr(status_clr), .reset_req(reset_req), .recover_req(recover_req),
        .flag_wd(flag_timeout), .flag_stp(flag_stop)
    );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        refresh,
    input logic        tick,
    input logic        stop_mode,
    input logic        status_clr,
    input logic        reset_req,
    input logic        recover_req,
    input logic        flag_timeout,
    input logic        flag_stop,
    input logic [15:0] reload_val,
    input logic [15:0] count
);
    // R7 and R8: the two requests are exclusive
    assert_one_request_R8: assert property (@(posedge clk) disable iff (rst)
        !(reset_req && recover_req));

    // R7: a reset request comes with the timeout flag, outside stop mode
    assert_reset_flags_R7: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (flag_timeout && !$past(stop_mode)));

    // R8: a recovery request comes with both flags, after a stop-mode cycle
    assert_recover_flags_R8: assert property (@(posedge clk) disable iff (rst)
        recover_req |-> (flag_timeout && flag_stop && $past(stop_mode)));

    // R4: the reload value only moves right after a write
    assert_reload_by_write_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(reload_val)) |-> $past(wr_en));

    // R6: with no tick and no refresh, the count holds
    assert_count_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick) && !$past(refresh)) |-> $stable(count));

    // R10: the flags fall only after a clear
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($fell(flag_timeout) || $fell(flag_stop))) |-> $past(status_clr));
endmodule

bind wdog_guard wdog_guard_chk u_chk (.*);

// File: tb/test_wdog_guard.sv
module test_wdog_guard;
    localparam logic [15:0] P_COUNT  = 16'd6;
    localparam logic [15:0] P_RELOAD = 16'd8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_hi = 0, refresh = 0, tick = 0, stop_mode = 0;
    logic cfg_reset_en = 0, cfg_stop_run = 0, status_clr = 0;
    logic [7:0] wr_data = 0;
    logic reset_req, recover_req, flag_timeout, flag_stop;
    logic [15:0] reload_val, count;

    always #5 clk = ~clk;

    wdog_guard #(.RST_COUNT(P_COUNT), .RST_RELOAD(P_RELOAD)) i_wdog_guard (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .refresh(refresh), .tick(tick), .stop_mode(stop_mode),
        .cfg_reset_en(cfg_reset_en), .cfg_stop_run(cfg_stop_run),
        .status_clr(status_clr), .reset_req(reset_req), .recover_req(recover_req),
        .flag_timeout(flag_timeout), .flag_stop(flag_stop),
        .reload_val(reload_val), .count(count)
    );

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic [15:0] rel;
        logic        rr, rq, fw, fs;
    } exp_t;
    exp_t q[$];

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state (expected after next edge)
    logic [15:0] m_cnt = P_COUNT, m_rel = P_RELOAD;
    logic m_fw = 0, m_fs = 0;
    int m_lk = 0; // 0 shut, 1 keyed, 2 want upper, 3 want lower

    // driver: apply inputs at the current negedge, predict, push, wait
    task automatic step(input bit we, input bit hi, input logic [7:0] d,
                        input bit rf, input bit tk, input bit clr, input string tag);
        exp_t e;
        bit run, to;
        logic [15:0] rel_old;
        wr_en = we; wr_hi = hi; wr_data = d; refresh = rf; tick = tk; status_clr = clr;
        rel_old = m_rel;
        run = tk && (!stop_mode || cfg_stop_run);
        to = 0;
        if (rf) m_cnt = rel_old;
        else if (run) begin
            if (m_cnt <= 16'd1) begin to = 1; m_cnt = rel_old; end
            else m_cnt = m_cnt - 16'd1;
        end
        e.rr = to && cfg_reset_en && !stop_mode;
        e.rq = to && cfg_reset_en && stop_mode;
        if (clr) begin m_fw = 0; m_fs = 0; end
        if (e.rr || e.rq) m_fw = 1;
        if (e.rq) m_fs = 1;
        if (we) begin
            case (m_lk)
                0: m_lk = (hi && d == 8'h55) ? 1 : 0;
                1: m_lk = (hi && d == 8'hAA) ? 2 : 0;
                2: begin if (hi) begin m_rel[15:8] = d; m_lk = 3; end else m_lk = 0; end
                default: begin if (!hi) m_rel[7:0] = d; m_lk = 0; end
            endcase
        end
        e.tag = tag; e.cnt = m_cnt; e.rel = m_rel; e.fw = m_fw; e.fs = m_fs;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 8'h00, 0, 0, 0, tag);
    endtask

    task automatic wr(input bit hi, input logic [7:0] d, input string tag);
        step(1, hi, d, 0, 0, 0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 1, 0, tag);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (count !== e.cnt || reload_val !== e.rel || reset_req !== e.rr ||
                recover_req !== e.rq || flag_timeout !== e.fw || flag_stop !== e.fs) begin
                fails++;
                $display("FAIL %s: got cnt=%h rel=%h rr=%b rq=%b fw=%b fs=%b exp cnt=%h rel=%h rr=%b rq=%b fw=%b fs=%b",
                    e.tag, count, reload_val, reset_req, recover_req, flag_timeout, flag_stop,
                    e.cnt, e.rel, e.rr, e.rq, e.fw, e.fs);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during and right after reset
        checks++;
        if (count !== P_COUNT || reload_val !== P_RELOAD || reset_req || recover_req ||
            flag_timeout || flag_stop) begin
            fails++;
            $display("FAIL R1: got cnt=%h rel=%h exp cnt=%h rel=%h", count, reload_val, P_COUNT, P_RELOAD);
        end
        rst = 0;
        idle("R1");

        cfg_reset_en = 1;
        ticks(5, "R6");          // 6 -> 1
        ticks(1, "R7");          // timeout, reload 8
        idle("R7");              // pulse gone, flag stays
        ticks(3, "R6");
        step(0, 0, 8'h00, 1, 1, 0, "R5");   // refresh beats tick
        idle("R10");
        step(0, 0, 8'h00, 0, 0, 1, "R10");  // clear
        ticks(7, "R6");                      // count 1
        step(0, 0, 8'h00, 0, 1, 1, "R10");  // timeout with clear: set wins
        step(0, 0, 8'h00, 0, 0, 1, "R10");

        // R4: locked and broken-order writes
        wr(1, 8'h12, "R4");
        wr(0, 8'h34, "R4");
        wr(1, 8'h55, "R4"); wr(0, 8'h56, "R4");
        wr(1, 8'hAA, "R4"); wr(1, 8'h77, "R4");
        wr(1, 8'h55, "R4"); wr(1, 8'h55, "R4"); wr(1, 8'hAA, "R4"); wr(1, 8'h78, "R4");
        wr(1, 8'h55, "R4"); wr(1, 8'hAA, "R4"); wr(0, 8'h21, "R4"); wr(1, 8'h01, "R4");
        wr(1, 8'h55, "R4"); wr(1, 8'hAA, "R4"); wr(1, 8'h02, "R4"); wr(1, 8'h03, "R4");
        wr(0, 8'h04, "R4");

        // R2 and R3: the full order
        wr(1, 8'h55, "R2"); idle("R2"); wr(1, 8'hAA, "R2");
        wr(1, 8'h00, "R3");
        wr(0, 8'h03, "R3");
        wr(1, 8'h09, "R3"); wr(0, 8'h09, "R3");

        step(0, 0, 8'h00, 1, 0, 0, "R5");   // count 3
        stop_mode = 1; cfg_stop_run = 0;
        ticks(3, "R9");
        cfg_stop_run = 1;
        ticks(3, "R8");
        idle("R8");
        stop_mode = 0; cfg_reset_en = 0;
        step(0, 0, 8'h00, 0, 0, 1, "R11");
        ticks(4, "R11");
        idle("R11");

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule